// File: doc/BRIEF.md
# Network Interface Packetizer

This block is the transmit side of a network interface for a quality-of-service network-on-chip. A core hands it one request at a time: a destination coordinate pair, a command word, a two-bit service level, and a flag that says whether payload words follow. The block then turns the request into a stream of flits for the local router.

The first flit is a header that packs the destination and the command. Each payload word, taken from a separate word stream that carries a last marker, then leaves as one flit. Every flit carries a two-bit type tag and the service level of its packet.

Payload length is unbounded and may be zero. A request without payload leaves as a single full-packet flit. Both the core side and the router side use valid/ready handshakes. The output flit sits in a register that can be refilled in the same cycle in which the router takes it, so a packet of N payload words can leave in N+1 back-to-back cycles.

Top module: `ni_packetizer`

## Requirements
- R1: The header flit carries the X coordinate in bits [31:28], the Y coordinate in bits [27:24] and the command in bits [23:0] of the 32-bit flit.
- R2: A request with the payload flag low produces exactly one flit, the header, typed full-packet (type code 2'b10).
- R3: A request with the payload flag high produces a header typed body (2'b00), then one flit per payload word in arrival order carrying that word unchanged. Each is typed body (2'b00), except the word marked last, which is typed end-of-packet (2'b01).
- R4: A valid output flit never carries type code 2'b11.
- R5: The service level captured with the request appears unchanged on every flit of that packet.
- R6: While the output is valid and the router's ready is low, the flit data, type and service level stay unchanged and valid stays high.
- R7: Request ready stays low from the acceptance of a request until the router has taken that packet's final (end-of-packet or full-packet) flit.
- R8: Payload ready is high only while a packet with payload is in progress and its last word has not yet been accepted.
- R9: After reset the output is not valid, request ready is high and payload ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Packetizer can accept a request |
| req_dest_x | input | 4 | Destination X coordinate |
| req_dest_y | input | 4 | Destination Y coordinate |
| req_cmd | input | 24 | Command word placed in the header |
| req_svc | input | 2 | Service level of the packet |
| req_has_pl | input | 1 | High when payload words follow |
| pl_valid | input | 1 | Payload word present |
| pl_ready | output | 1 | Payload word accepted this cycle |
| pl_data | input | 32 | Payload word |
| pl_last | input | 1 | Marks the final payload word |
| flit_valid | output | 1 | Output flit present |
| flit_ready | input | 1 | Router takes the flit |
| flit_data | output | 32 | Flit contents |
| flit_type | output | 2 | 00 body, 01 end-of-packet, 10 full-packet |
| flit_svc | output | 2 | Service level of the flit's packet |

## Verification
The bench builds the block with its default parameters: 32-bit flits, 4-bit coordinates and a 2-bit service level. This leaves a 24-bit command field and makes every coordinate and service value reachable. Directed packets cover header-only requests back to back, single-word payloads, a long payload and the extreme coordinates. Several hundred random packets follow, with random payload gaps and random router back-pressure. Together they reach stalls on the header, on body flits and on the final flit, and same-cycle refill of the output register.

// File: rtl/ni_packetizer.sv
module ni_packetizer #(
  parameter int FLIT_W  = 32,
  parameter int COORD_W = 4,
  parameter int SVC_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [COORD_W-1:0]            req_dest_x,
  input  logic [COORD_W-1:0]            req_dest_y,
  input  logic [FLIT_W-2*COORD_W-1:0]   req_cmd,
  input  logic [SVC_W-1:0]              req_svc,
  input  logic                          req_has_pl,
  input  logic                          pl_valid,
  output logic                          pl_ready,
  input  logic [FLIT_W-1:0]             pl_data,
  input  logic                          pl_last,
  output logic                          flit_valid,
  input  logic                          flit_ready,
  output logic [FLIT_W-1:0]             flit_data,
  output logic [1:0]                    flit_type,
  output logic [SVC_W-1:0]              flit_svc
);

  localparam logic [1:0] T_BDY = 2'b00;
  localparam logic [1:0] T_EP  = 2'b01;
  localparam logic [1:0] T_FP  = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_PAY, ST_LAST} st_t;
  st_t state;

  logic             out_vld;
  logic [FLIT_W-1:0] out_data;
  logic [1:0]       out_type;
  logic [SVC_W-1:0] out_svc;

  logic out_free, req_fire, pl_fire, out_fire;

  assign out_free  = !out_vld || flit_ready;
  assign req_ready = (state == ST_IDLE);
  assign pl_ready  = (state == ST_PAY) && out_free;
  assign req_fire  = req_valid && req_ready;
  assign pl_fire   = pl_valid && pl_ready;
  assign out_fire  = out_vld && flit_ready;

  assign flit_valid = out_vld;
  assign flit_data  = out_data;
  assign flit_type  = out_type;
  assign flit_svc   = out_svc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      out_vld  <= 1'b0;
      out_data <= '0;
      out_type <= T_BDY;
      out_svc  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_fire) begin
          out_vld  <= 1'b1;
          out_data <= {req_dest_x, req_dest_y, req_cmd};
          out_type <= req_has_pl ? T_BDY : T_FP;
          out_svc  <= req_svc;
          state    <= req_has_pl ? ST_PAY : ST_LAST;
        end
        ST_PAY: begin
          if (pl_fire) begin
            out_vld  <= 1'b1;
            out_data <= pl_data;
            out_type <= pl_last ? T_EP : T_BDY;
            if (pl_last) state <= ST_LAST;
          end else if (out_fire) begin
            out_vld <= 1'b0;
          end
        end
        ST_LAST: if (out_fire) begin
          out_vld <= 1'b0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_NO_RSVD_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> flit_type != 2'b11); // R4

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && !flit_ready) |=> (flit_valid && $stable(flit_data)
      && $stable(flit_type) && $stable(flit_svc))); // R6

  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> !req_ready); // R7

  AST_HDR_ONLY_FP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !req_has_pl) |=> (flit_valid && flit_type == T_FP)); // R2

  AST_HDR_BDY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_has_pl) |=> (flit_valid && flit_type == T_BDY)); // R3

  AST_SVC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_fire |=> $stable(flit_svc)); // R5

  AST_PL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> !req_ready); // R8

endmodule

// File: tb/ni_packetizer_tb.sv
module ni_packetizer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_RAND   = 300;
  localparam int MAX_LEN    = 40;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [3:0] req_dest_x = 0, req_dest_y = 0;
  logic [23:0] req_cmd = 0;
  logic [1:0] req_svc = 0;
  logic req_has_pl = 0;
  logic pl_valid = 0, pl_ready, pl_last = 0;
  logic [31:0] pl_data = 0;
  logic flit_valid, flit_ready = 0;
  logic [31:0] flit_data;
  logic [1:0] flit_type, flit_svc;

  always #(CLK_PERIOD/2) clk = ~clk;

  ni_packetizer u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_dest_x(req_dest_x), .req_dest_y(req_dest_y),
    .req_cmd(req_cmd), .req_svc(req_svc), .req_has_pl(req_has_pl),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data), .pl_last(pl_last),
    .flit_valid(flit_valid), .flit_ready(flit_ready),
    .flit_data(flit_data), .flit_type(flit_type), .flit_svc(flit_svc)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] hdr_word(input logic [3:0] x, input logic [3:0] y, input logic [23:0] c);
    return {x, y, c};
  endfunction

  function automatic logic [1:0] exp_type(input int idx, input int len);
    if (len == 0) return 2'b10;
    if (idx == len) return 2'b01;
    return 2'b00;
  endfunction

  logic [31:0] q_data[$];
  logic [1:0]  q_type[$];
  logic [1:0]  q_svc[$];
  string       q_req[$];

  logic [31:0] pay [MAX_LEN];
  int cur_len, pidx;
  bit have_pkt, req_done, pkt_open;
  int pkt_no, gap;
  bit stall_prev;
  logic [31:0] st_data; logic [1:0] st_type, st_svc;

  task automatic new_packet(input int n);
    logic [3:0] x, y; logic [23:0] c; logic [1:0] s;
    x = 4'($urandom); y = 4'($urandom); c = 24'($urandom); s = 2'($urandom);
    cur_len = $urandom_range(0, 6);
    case (n)
      0: begin cur_len = 0; x = 4'hF; y = 4'h0; end
      1: begin cur_len = 0; x = 4'h0; y = 4'hF; end
      2: cur_len = 1;
      3: begin cur_len = MAX_LEN; s = 2'd3; end
      4: begin cur_len = 2; s = 2'd1; end
      default: if ($urandom_range(0, 15) == 0) cur_len = $urandom_range(7, MAX_LEN);
    endcase
    for (int i = 0; i < cur_len; i++) pay[i] = $urandom;
    req_dest_x = x; req_dest_y = y; req_cmd = c; req_svc = s; req_has_pl = (cur_len != 0);
    q_data.push_back(hdr_word(x, y, c)); q_type.push_back(exp_type(0, cur_len));
    q_svc.push_back(s); q_req.push_back(cur_len == 0 ? "R1/R2" : "R1/R3");
    for (int i = 1; i <= cur_len; i++) begin
      q_data.push_back(pay[i-1]); q_type.push_back(exp_type(i, cur_len));
      q_svc.push_back(s); q_req.push_back("R3");
    end
    pidx = 0; req_done = 0; have_pkt = 1;
  endtask

  initial begin
    int cyc;
    have_pkt = 0; pkt_open = 0; pkt_no = 0; gap = 0; stall_prev = 0;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(req_ready === 1'b1, "R9 req_ready", 64'(req_ready), 1);
    check(flit_valid === 1'b0, "R9 flit_valid", 64'(flit_valid), 0);
    check(pl_ready === 1'b0, "R9 pl_ready", 64'(pl_ready), 0);
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        check(0, "watchdog", 64'(cyc), 0);
        break;
      end
      if (!have_pkt && pkt_no < NUM_RAND + 5 && !pkt_open) begin
        if (gap > 0) gap--;
        else begin new_packet(pkt_no); pkt_no++; gap = $urandom_range(0, 2); end
      end
      req_valid = have_pkt && !req_done;
      if (have_pkt && req_done && pidx < cur_len && $urandom_range(0, 3) != 0) begin
        pl_valid = 1; pl_data = pay[pidx]; pl_last = (pidx == cur_len - 1);
      end else begin
        pl_valid = 0; pl_data = 32'($urandom); pl_last = 1'($urandom);
      end
      flit_ready = (pkt_no < 5) ? 1'b1 : ($urandom_range(0, 2) != 0);
      #1;
      if (stall_prev) begin
        check(flit_valid === 1'b1, "R6 valid held", 64'(flit_valid), 1);
        check(flit_data === st_data, "R6 data held", 64'(flit_data), 64'(st_data));
        check(flit_type === st_type && flit_svc === st_svc, "R6 type/svc held",
              64'({flit_type, flit_svc}), 64'({st_type, st_svc}));
      end
      check(!(pkt_open && req_ready), "R7 req_ready during packet", 64'(req_ready), 0);
      check(!(pl_ready && !(pkt_open && pidx < cur_len)), "R8 pl_ready gating", 64'(pl_ready), 0);
      if (flit_valid) check(flit_type != 2'b11, "R4 reserved type", 64'(flit_type), 0);
      stall_prev = flit_valid && !flit_ready;
      st_data = flit_data; st_type = flit_type; st_svc = flit_svc;
      if (req_valid && req_ready) begin req_done = 1; pkt_open = 1; end
      if (pl_valid && pl_ready) pidx++;
      if (flit_valid && flit_ready) begin
        if (q_data.size() == 0) check(0, "R2/R3 extra flit", 64'(flit_data), 0);
        else begin
          logic [31:0] ed; logic [1:0] et, es; string r;
          ed = q_data.pop_front(); et = q_type.pop_front(); es = q_svc.pop_front(); r = q_req.pop_front();
          check(flit_data === ed, {r, " data"}, 64'(flit_data), 64'(ed));
          check(flit_type === et, {r, " type"}, 64'(flit_type), 64'(et));
          check(flit_svc === es, "R5 svc", 64'(flit_svc), 64'(es));
          if (et != 2'b00) begin pkt_open = 0; have_pkt = 0; end
        end
      end
      if (pkt_no >= NUM_RAND + 5 && !have_pkt && !pkt_open) break;
    end
    check(q_data.size() == 0, "R3 all flits emitted", 64'(q_data.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule